// File: doc/BRIEF.md
# AHCI Global Host Control Register

This block is the global control word of an AHCI-style SATA host controller. The word is 32 bits wide and sits behind a simple single-register write/read port. It has three writable bits. The top bit selects AHCI-style access over legacy access. Bit 1 is a global interrupt enable, which gates the pending-interrupt inputs of all ports onto one interrupt output. Bit 0 is a controller-reset bit.

Writing 1 to the reset bit starts an internal reset sequencer, which runs in two phases:
- **Drain phase:** the sequencer holds an idle request to the transfer and queuing state machines for a fixed number of cycles.
- **Re-init phase:** it then asks every port to re-initialize through a link reset for a fixed number of cycles.

The reset bit reads 1 for the whole sequence and then clears itself. Starting the sequence also returns the mode and interrupt enables to 0.

Bit 2 is read-only and is computed from the MSI capability fields. It reports that the controller has fallen back to a single MSI vector. The requested and allocated message counts arrive as 3-bit power-of-two codes, where code k means 2^k vectors.

Top module: `ghc_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 0x00000000, `irq_out` is 0, and neither `idle_req` nor any `port_reinit_req` bit is asserted.
- R2: Bit 31 (mode enable) is read/write: a write outside a reset sequence loads it from `wr_data[31]`, and it drives `ahci_mode`.
- R3: Bits 30 down to 3 always read 0, and writing 1s to them has no effect.
- R4: Bit 2 reads 1 exactly when `msi_enable`=1, `msi_req_code`≠0, `msi_alloc_code`≠0 and `msi_alloc_code`≠`msi_req_code`; otherwise it reads 0. Writes to bit 2 are ignored.
- R5: With `msi_enable`=1 and `msi_alloc_code`=0, bit 2 reads 0 for every requested code.
- R6: While bit 0 reads 1, bit 2 reads 0 whatever the MSI inputs are.
- R7: Bit 1 is read/write, and `irq_out` equals bit 1 AND the OR of all `port_irq_pend` bits.
- R8: A write with `wr_data[0]`=1 while bit 0 is 0 makes bit 0 read 1 from the next cycle for exactly DRAIN_CYC+REINIT_CYC cycles, after which it reads 0. A write with `wr_data[0]`=0 starts nothing.
- R9: During a reset sequence, `idle_req` is high for the first DRAIN_CYC cycles. Then all `port_reinit_req` bits are high together for the following REINIT_CYC cycles. The two never overlap.
- R10: Starting a reset sequence clears bits 31 and 1, and writes are ignored while bit 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| msi_enable | input | 1 | MSI enabled in the capability |
| msi_req_code | input | 3 | Requested vector count, log2 code |
| msi_alloc_code | input | 3 | Allocated vector count, log2 code |
| port_irq_pend | input | NPORTS | Per-port pending interrupt |
| irq_out | output | 1 | Gated controller interrupt |
| ahci_mode | output | 1 | Mode enable (bit 31) |
| idle_req | output | 1 | Return-to-idle request to transfer/queue machines |
| port_reinit_req | output | NPORTS | Per-port re-initialization request |

## Verification
All 128 combinations of MSI enable, requested code and allocated code are swept. This tells apart each of the four conditions of the fallback rule, including the programmed single-vector case in which the allocation is zero. Every pattern of the four pending bits is applied with the interrupt enable off and then on, which separates the gating from the OR. A reset sequence is run with the fallback condition true, pending interrupts active and a write attempted mid-sequence. Phase lengths, phase order, status masking and the cleared enables are all measured in that one run.

// File: rtl/ghc_pkg.sv
package ghc_pkg;

    localparam int REG_W      = 32;
    localparam int MSI_CODE_W = 3;

    // Bit positions decoded by software; they define the register layout.
    localparam int BIT_MODE   = 31;
    localparam int BIT_MSI1   = 2;
    localparam int BIT_IRQEN  = 1;
    localparam int BIT_CRST   = 0;

    localparam logic [REG_W-1:0] RW_MASK =
        (REG_W'(1) << BIT_MODE) | (REG_W'(1) << BIT_IRQEN) | (REG_W'(1) << BIT_CRST);

    typedef struct packed {
        logic mode;
        logic irq_en;
        logic crst;
    } ghc_ctl_t;

    typedef struct packed {
        logic                  enable;
        logic [MSI_CODE_W-1:0] req;
        logic [MSI_CODE_W-1:0] alloc;
    } msi_cap_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_DRAIN  = 2'd1,
        SEQ_REINIT = 2'd2
    } seq_state_e;

    function automatic logic msi_fell_back(msi_cap_t c);
        return c.enable && (c.req != '0) && (c.alloc != '0) && (c.alloc != c.req);
    endfunction

    function automatic logic [REG_W-1:0] pack_word(ghc_ctl_t c, logic msi1);
        logic [REG_W-1:0] w;
        w            = '0;
        w[BIT_MODE]  = c.mode;
        w[BIT_MSI1]  = msi1;
        w[BIT_IRQEN] = c.irq_en;
        w[BIT_CRST]  = c.crst;
        return w;
    endfunction

endpackage

// File: rtl/ghc_msi_status.sv
module ghc_msi_status
    import ghc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  msi_cap_t cap,
    input  logic     crst_active,
    output logic     fallback
);

    always_comb begin
        fallback = !crst_active && msi_fell_back(cap);
    end

    AST_PROGRAMMED_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cap.enable && cap.alloc == '0) |-> !fallback); // R5

    AST_MASK_IN_CRST: assert property (@(posedge clk) disable iff (rst)
        crst_active |-> !fallback); // R6

endmodule

// File: rtl/ghc_rst_seq.sv
module ghc_rst_seq
    import ghc_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int DRAIN_CYC  = 4,
    parameter int REINIT_CYC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              idle_req,
    output logic [NPORTS-1:0] port_reinit_req,
    output logic              done
);

    localparam int MAXC = (DRAIN_CYC > REINIT_CYC) ? DRAIN_CYC : REINIT_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] DRAIN_LAST  = CW'(DRAIN_CYC - 1);
    localparam logic [CW-1:0] REINIT_LAST = CW'(REINIT_CYC - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (start) state_q <= SEQ_DRAIN;
                end
                SEQ_DRAIN: begin
                    if (cnt_q == DRAIN_LAST) begin
                        state_q <= SEQ_REINIT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_REINIT: begin
                    if (cnt_q == REINIT_LAST) begin
                        state_q <= SEQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SEQ_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign idle_req = (state_q == SEQ_DRAIN);
    assign done     = (state_q == SEQ_REINIT) && (cnt_q == REINIT_LAST);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign port_reinit_req[p] = (state_q == SEQ_REINIT);
    end

    AST_PHASES_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        !(idle_req && (|port_reinit_req))); // R9

    AST_REINIT_ALL_PORTS: assert property (@(posedge clk) disable iff (rst)
        (|port_reinit_req) |-> (&port_reinit_req)); // R9

    AST_DRAIN_THEN_REINIT: assert property (@(posedge clk) disable iff (rst)
        (idle_req && cnt_q == DRAIN_LAST) |=> (&port_reinit_req)); // R9

endmodule

// File: rtl/ghc_ctl_regs.sv
module ghc_ctl_regs
    import ghc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             seq_done,
    output ghc_ctl_t         ctl,
    output logic             seq_start
);

    logic [REG_W-1:0] wr_val;

    assign wr_val    = wr_data & RW_MASK;
    assign seq_start = wr_en && !ctl.crst && wr_val[BIT_CRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (ctl.crst) begin
            if (seq_done) ctl.crst <= 1'b0;
        end else if (wr_en) begin
            if (wr_val[BIT_CRST]) begin
                ctl.mode   <= 1'b0;
                ctl.irq_en <= 1'b0;
                ctl.crst   <= 1'b1;
            end else begin
                ctl.mode   <= wr_val[BIT_MODE];
                ctl.irq_en <= wr_val[BIT_IRQEN];
            end
        end
    end

    AST_CRST_ENABLES_LOW: assert property (@(posedge clk) disable iff (rst)
        ctl.crst |-> (!ctl.mode && !ctl.irq_en)); // R10

    AST_CRST_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ctl.crst && !seq_done) |=> ctl.crst); // R8

    AST_CRST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ctl.crst && seq_done) |=> !ctl.crst); // R8

    AST_ZERO_WRITE_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!ctl.crst && !(wr_en && wr_data[BIT_CRST])) |=> !ctl.crst); // R8

endmodule

// File: rtl/ghc_ctrl.sv
module ghc_ctrl
    import ghc_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int DRAIN_CYC  = 4,
    parameter int REINIT_CYC = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wr_data,
    output logic [REG_W-1:0]      rd_data,
    input  logic                  msi_enable,
    input  logic [MSI_CODE_W-1:0] msi_req_code,
    input  logic [MSI_CODE_W-1:0] msi_alloc_code,
    input  logic [NPORTS-1:0]     port_irq_pend,
    output logic                  irq_out,
    output logic                  ahci_mode,
    output logic                  idle_req,
    output logic [NPORTS-1:0]     port_reinit_req
);

    ghc_ctl_t ctl;
    msi_cap_t cap;
    logic     seq_start;
    logic     seq_done;
    logic     msi1;

    assign cap = '{enable: msi_enable, req: msi_req_code, alloc: msi_alloc_code};

    ghc_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .seq_done  (seq_done),
        .ctl       (ctl),
        .seq_start (seq_start)
    );

    ghc_rst_seq #(
        .NPORTS     (NPORTS),
        .DRAIN_CYC  (DRAIN_CYC),
        .REINIT_CYC (REINIT_CYC)
    ) u_seq (
        .clk             (clk),
        .rst             (rst),
        .start           (seq_start),
        .idle_req        (idle_req),
        .port_reinit_req (port_reinit_req),
        .done            (seq_done)
    );

    ghc_msi_status u_msi (
        .clk         (clk),
        .rst         (rst),
        .cap         (cap),
        .crst_active (ctl.crst),
        .fallback    (msi1)
    );

    assign rd_data   = pack_word(ctl, msi1);
    assign irq_out   = ctl.irq_en && (|port_irq_pend);
    assign ahci_mode = ctl.mode;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !rd_data[BIT_IRQEN] |-> !irq_out); // R7

    AST_SEQ_ONLY_IN_CRST: assert property (@(posedge clk) disable iff (rst)
        (idle_req || (|port_reinit_req)) |-> rd_data[BIT_CRST]); // R9

    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-2:3] == '0); // R3

endmodule

// File: tb/ghc_ctrl_bench.sv
module ghc_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int DC   = 4;
    localparam int RC   = 6;
    localparam int WDOG = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        msi_enable;
    logic [2:0]  msi_req_code;
    logic [2:0]  msi_alloc_code;
    logic [NP-1:0] port_irq_pend;
    logic        irq_out;
    logic        ahci_mode;
    logic        idle_req;
    logic [NP-1:0] port_reinit_req;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ghc_ctrl #(.NPORTS(NP), .DRAIN_CYC(DC), .REINIT_CYC(RC)) u_ghc_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .msi_enable(msi_enable), .msi_req_code(msi_req_code),
        .msi_alloc_code(msi_alloc_code), .port_irq_pend(port_irq_pend),
        .irq_out(irq_out), .ahci_mode(ahci_mode), .idle_req(idle_req),
        .port_reinit_req(port_reinit_req)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic write_word(logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int hr_cyc, idle_cyc, re_cyc, first_re, last_idle, split_bad, masked_bad;
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        msi_enable = 1'b0; msi_req_code = '0; msi_alloc_code = '0; port_irq_pend = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        chk("R1 seq idle", {27'b0, idle_req, port_reinit_req}, 32'h0);

        // R2 R3: all-ones write except reset bit
        write_word(32'hFFFF_FFFE);
        chk("R2 R3 readback", rd_data, 32'h8000_0002);
        chk("R2 ahci_mode", {31'b0, ahci_mode}, 32'h1);
        write_word(32'h7FFF_FFFC);
        chk("R2 R3 cleared", rd_data, 32'h0);

        // R8: write of 0 starts nothing
        write_word(32'h0);
        for (int i = 0; i < DC + RC; i++) begin
            @(negedge clk);
            chk("R8 zero write no start", {rd_data[0], idle_req, port_reinit_req}, 32'h0);
        end

        // R7: irq gating sweep
        for (int e = 0; e < 2; e++) begin
            write_word(e ? 32'h2 : 32'h0);
            for (int p = 0; p < (1 << NP); p++) begin
                port_irq_pend = NP'(p);
                #1;
                chk("R7 irq_out", {31'b0, irq_out}, {31'b0, (e == 1) && (p != 0)});
            end
        end
        port_irq_pend = '0;

        // R4 R5: exhaustive MSI sweep
        for (int en = 0; en < 2; en++)
            for (int rq = 0; rq < 8; rq++)
                for (int al = 0; al < 8; al++) begin
                    msi_enable = en[0]; msi_req_code = 3'(rq); msi_alloc_code = 3'(al);
                    #1;
                    if (en == 1 && al == 0)
                        chk("R5 programmed single", {31'b0, rd_data[2]}, 32'h0);
                    else
                        chk("R4 fallback bit", {31'b0, rd_data[2]},
                            {31'b0, (en == 1) && (rq != 0) && (al != 0) && (al != rq)});
                end

        // R4: write to bit 2 ignored
        msi_enable = 1'b0;
        write_word(32'h0000_0006);
        chk("R4 bit2 not writable", rd_data, 32'h0000_0002);

        // R6 R8 R9 R10: reset sequence
        write_word(32'h8000_0002);
        msi_enable = 1'b1; msi_req_code = 3'd3; msi_alloc_code = 3'd1;
        port_irq_pend = 4'b0001;
        #1;
        chk("R4 fallback before reset", rd_data, 32'h8000_0006);
        write_word(32'h8000_0003);
        hr_cyc = 0; idle_cyc = 0; re_cyc = 0; first_re = -1; last_idle = -1;
        split_bad = 0; masked_bad = 0;
        while (rd_data[0] && hr_cyc < 100) begin
            hr_cyc++;
            if (idle_req) begin idle_cyc++; last_idle = hr_cyc; end
            if (|port_reinit_req) begin
                re_cyc++;
                if (first_re < 0) first_re = hr_cyc;
                if (!(&port_reinit_req)) split_bad++;
            end
            if (rd_data[2] || rd_data[31] || rd_data[1] || irq_out) masked_bad++;
            if (hr_cyc == 1) begin wr_en = 1'b1; wr_data = 32'h8000_0002; end
            else begin wr_en = 1'b0; wr_data = '0; end
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R8 reset bit duration", hr_cyc, DC + RC);
        chk("R9 idle_req cycles", idle_cyc, DC);
        chk("R9 reinit cycles", re_cyc, RC);
        chk("R9 phase order", {31'b0, last_idle < first_re}, 32'h1);
        chk("R9 all ports together", split_bad, 0);
        chk("R6 R10 masked during reset", masked_bad, 0);
        chk("R10 enables cleared, write ignored", rd_data, 32'h0000_0004);
        chk("R10 ahci_mode low", {31'b0, ahci_mode}, 32'h0);
        chk("R7 irq after reset", {31'b0, irq_out}, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule